// File: doc/BRIEF.md
# DMA Request Routing and Control

This block is the shared control core of a three-channel DMA controller. Each channel selects one of eight request sources with its own 3-bit code. A software trigger register can raise any of those sources without a peripheral. Requests from enabled channels go to a fixed-priority arbiter. The arbiter grants one channel at a time to the channel engines. The engines report each finished transfer unit and flag the unit that ends a block.

The core holds the completion flags, the interrupt enables and one interrupt line per channel. Flags clear only when software reads the status register and then writes a 0 to the flag. Two further rules are applied here. A priority bit decides whether a pending CPU interrupt may cut a block short. A wait-enable bit decides whether transfers continue while the processor sleeps. Address arithmetic and bus timing are handled in the channel engines, not here.

Top module: `dma_ctl_core`

## Requirements
- R1: After reset, every register reads 0, `gnt` is 0 and `irq` is 0. A read on `reg_re` returns its data on `reg_rdata` one clock later. The control register at address 0 has `bw` in [7:6], and the enable and interrupt-enable of channel c in bits 2c+1 and 2c. The status register at address 1 has the priority bit in [7], the loop enables of channels 2..0 in [6:4], the wait-enable in [3] and the flags of channels 2..0 in [2:0].
- R2: The source select of channel c is held in bits [2:0] of address 3+c. The codes are 0-3 for timer channels 0-3, 4 for SPI transmit, 5 for SPI receive, 6 for SCI receive and 7 for SCI transmit. An idle, enabled channel is granted one clock after `periph_req[select]` goes high. A request on any other source is not granted.
- R3: When several enabled channels request together, the lowest-numbered channel is granted first. `gnt` is never more than one-hot.
- R4: Writing bit n of the trigger register at address 2 requests source n. The bit clears when a channel is granted for that source. If no enabled channel selects source n, the bit stays set.
- R5: A unit with `xfer_last` set ends the block. It sets the channel's flag and releases the grant. If loop mode is off, it also clears the channel's enable.
- R6: With loop mode on, the end of a block sets the flag and keeps the enable, so the channel is granted again.
- R7: `irq[c]` is high one clock after flag c and interrupt-enable c are both 1.
- R8: A status write clears flag c only if its bit c is 0 and flag c was read as 1 since the last status write. A write of 0 without that read leaves the flag set.
- R9: With the priority bit 0, a unit that finishes while `cpu_irq_pend` is high releases the grant and clears the channel's enable. The flag is not set.
- R10: With the priority bit 1, `cpu_irq_pend` does not end the grant before the block ends.
- R11: While `wait_mode` is high and the wait-enable bit is 0, `gnt` is 0, and the grant returns when `wait_mode` falls. With the wait-enable bit set, grants continue during wait mode and flags and interrupts still fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| periph_req | input | 8 | Peripheral request lines, indexed by source code |
| cpu_irq_pend | input | 1 | A higher-priority CPU interrupt is pending |
| wait_mode | input | 1 | Processor is in wait mode |
| xfer_step | input | 1 | Granted engine finished one transfer unit |
| xfer_last | input | 1 | That unit ended the block |
| gnt | output | 3 | One-hot grant to the channel engines |
| bw | output | 2 | Bandwidth setting for the engines |
| loop_mode | output | 3 | Per-channel loop enables for the engines |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
A wrong select or enable shows up on `gnt` one clock after the request: the wrong channel lights, or no channel does. A damaged flag or arming bit shows on `irq` and in the status read within two clocks of the step or the write. A fault in the preemption, loop or wait logic shows as `gnt` staying on or dropping wrongly after the step, or as an enable bit reading back wrong.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int NCH_DEF  = 3;
  localparam int NSRC_DEF = 8;
  localparam int DW_DEF   = 8;
  localparam int AW_DEF   = 3;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_TRIG  = 2;
  localparam int ADDR_SEL0  = 3;
endpackage

// File: rtl/dma_req_route.sv
module dma_req_route #(
  parameter int NCH  = 3,
  parameter int NSRC = 8,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic [NCH*SELW-1:0] sel_flat,
  input  logic [NCH-1:0]      ch_en,
  input  logic [NSRC-1:0]     src_req,
  output logic [NCH-1:0]      ch_req
);
  for (genvar c = 0; c < NCH; c++) begin : g_route
    logic [SELW-1:0] sel_c;
    assign sel_c     = sel_flat[c*SELW +: SELW];
    assign ch_req[c] = ch_en[c] & src_req[sel_c];
  end
endmodule

// File: rtl/dma_fixed_arb.sv
module dma_fixed_arb #(
  parameter int NCH = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           win_vld,
  output logic [CHW-1:0] win_idx
);
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (req[c]) begin
        win_vld = 1'b1;
        win_idx = CHW'(c);
      end
    end
  end
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_i,
  input  logic           rd_hit,
  input  logic           wr_hit,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] ie,
  output logic [NCH-1:0] flag_o,
  output logic [NCH-1:0] armed_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] flag_q, armed_q, flag_d, armed_d;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    for (int c = 0; c < NCH; c++) begin
      if (rd_hit && flag_q[c]) armed_d[c] = 1'b1;
      if (wr_hit) begin
        if (armed_q[c] && !wbits[c]) flag_d[c] = 1'b0;
        armed_d[c] = 1'b0;
      end
      if (set_i[c]) begin
        flag_d[c]  = 1'b1;
        armed_d[c] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      armed_q <= '0;
      irq_o   <= '0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
      irq_o   <= flag_d & ie;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/dma_ctl_core.sv
module dma_ctl_core #(
  parameter int NCH  = dma_ctl_pkg::NCH_DEF,
  parameter int NSRC = dma_ctl_pkg::NSRC_DEF,
  parameter int DW   = dma_ctl_pkg::DW_DEF,
  parameter int AW   = dma_ctl_pkg::AW_DEF,
  localparam int SELW = $clog2(NSRC),
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] periph_req,
  input  logic            cpu_irq_pend,
  input  logic            wait_mode,
  input  logic            xfer_step,
  input  logic            xfer_last,
  output logic [NCH-1:0]  gnt,
  output logic [1:0]      bw,
  output logic [NCH-1:0]  loop_mode,
  output logic [NCH-1:0]  irq
);
  import dma_ctl_pkg::*;

  localparam int ST_WAKE = NCH;
  localparam int ST_LOOP = NCH + 1;
  localparam int ST_PRI  = 2 * NCH + 1;

  logic [1:0]      bw_r;
  logic [NCH-1:0]  en_r, ie_r, loop_r;
  logic            pri_r, wake_r;
  logic [NSRC-1:0] trig_r;
  logic [SELW-1:0] sel_r [NCH];
  logic            act_r;
  logic [CHW-1:0]  act_ch;
  logic [NCH-1:0]  gnt_r;
  logic [DW-1:0]   rdata_r;

  logic wr_ctrl, wr_stat, wr_trig, rd_stat;
  assign wr_ctrl = reg_we && (reg_addr == AW'(ADDR_CTRL));
  assign wr_stat = reg_we && (reg_addr == AW'(ADDR_STAT));
  assign wr_trig = reg_we && (reg_addr == AW'(ADDR_TRIG));
  assign rd_stat = reg_re && (reg_addr == AW'(ADDR_STAT));

  // request routing
  logic [NCH*SELW-1:0] sel_flat;
  logic [NCH-1:0]      ch_req;
  for (genvar c = 0; c < NCH; c++) begin : g_flat
    assign sel_flat[c*SELW +: SELW] = sel_r[c];
  end

  dma_req_route #(.NCH(NCH), .NSRC(NSRC)) route_i (
    .sel_flat (sel_flat),
    .ch_en    (en_r),
    .src_req  (periph_req | trig_r),
    .ch_req   (ch_req)
  );

  logic           pick_vld;
  logic [CHW-1:0] pick_idx;
  dma_fixed_arb #(.NCH(NCH)) arb_i (
    .req     (ch_req),
    .win_vld (pick_vld),
    .win_idx (pick_idx)
  );

  // grant control
  logic susp, step_ok, block_end, preempt, release_g, grant_new;
  assign susp      = wait_mode & ~wake_r;
  assign step_ok   = act_r & xfer_step & (|gnt_r);
  assign block_end = step_ok & xfer_last;
  assign preempt   = step_ok & ~xfer_last & ~pri_r & cpu_irq_pend;
  assign release_g = block_end | preempt;
  assign grant_new = ~act_r & pick_vld & ~susp;

  logic [NCH-1:0] en_clr, flag_set, en_d, gnt_d;
  logic [NSRC-1:0] trig_d;
  logic           act_d;
  logic [CHW-1:0] act_ch_d;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      en_clr[c]   = (act_ch == CHW'(c)) & ((block_end & ~loop_r[c]) | preempt);
      flag_set[c] = (act_ch == CHW'(c)) & block_end;
    end
    en_d = en_r;
    if (wr_ctrl) begin
      for (int c = 0; c < NCH; c++) en_d[c] = reg_wdata[2*c+1];
    end
    en_d = en_d & ~en_clr;

    trig_d = wr_trig ? reg_wdata[NSRC-1:0] : trig_r;
    if (grant_new) trig_d[sel_r[pick_idx]] = 1'b0;

    act_d    = release_g ? 1'b0 : (act_r | grant_new);
    act_ch_d = grant_new ? pick_idx : act_ch;
    for (int c = 0; c < NCH; c++)
      gnt_d[c] = act_d & (act_ch_d == CHW'(c)) & ~susp;
  end

  // read mux
  logic [DW-1:0] ctrl_rd, stat_rd, rd_d;
  logic [NCH-1:0] flag_w, armed_w;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[DW-1 -: 2] = bw_r;
    for (int c = 0; c < NCH; c++) begin
      ctrl_rd[2*c+1] = en_r[c];
      ctrl_rd[2*c]   = ie_r[c];
    end
    stat_rd = '0;
    stat_rd[NCH-1:0]             = flag_w;
    stat_rd[ST_WAKE]             = wake_r;
    stat_rd[ST_LOOP +: NCH]      = loop_r;
    stat_rd[ST_PRI]              = pri_r;
    rd_d = '0;
    if (reg_addr == AW'(ADDR_CTRL)) rd_d = ctrl_rd;
    if (reg_addr == AW'(ADDR_STAT)) rd_d = stat_rd;
    if (reg_addr == AW'(ADDR_TRIG)) rd_d = DW'(trig_r);
    for (int c = 0; c < NCH; c++)
      if (reg_addr == AW'(ADDR_SEL0 + c)) rd_d = DW'(sel_r[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bw_r    <= '0;
      en_r    <= '0;
      ie_r    <= '0;
      loop_r  <= '0;
      pri_r   <= 1'b0;
      wake_r  <= 1'b0;
      trig_r  <= '0;
      act_r   <= 1'b0;
      act_ch  <= '0;
      gnt_r   <= '0;
      rdata_r <= '0;
      for (int c = 0; c < NCH; c++) sel_r[c] <= '0;
    end else begin
      en_r   <= en_d;
      trig_r <= trig_d;
      act_r  <= act_d;
      act_ch <= act_ch_d;
      gnt_r  <= gnt_d;
      if (reg_re) rdata_r <= rd_d;
      if (wr_ctrl) begin
        bw_r <= reg_wdata[DW-1 -: 2];
        for (int c = 0; c < NCH; c++) ie_r[c] <= reg_wdata[2*c];
      end
      if (wr_stat) begin
        wake_r <= reg_wdata[ST_WAKE];
        loop_r <= reg_wdata[ST_LOOP +: NCH];
        pri_r  <= reg_wdata[ST_PRI];
      end
      for (int c = 0; c < NCH; c++)
        if (reg_we && (reg_addr == AW'(ADDR_SEL0 + c)))
          sel_r[c] <= reg_wdata[SELW-1:0];
    end
  end

  dma_flag_bank #(.NCH(NCH)) flags_i (
    .clk     (clk),
    .rst     (rst),
    .set_i   (flag_set),
    .rd_hit  (rd_stat),
    .wr_hit  (wr_stat),
    .wbits   (reg_wdata[NCH-1:0]),
    .ie      (ie_r),
    .flag_o  (flag_w),
    .armed_o (armed_w),
    .irq_o   (irq)
  );

  assign gnt       = gnt_r;
  assign bw        = bw_r;
  assign loop_mode = loop_r;
  assign reg_rdata = rdata_r;
endmodule

// File: rtl/dma_ctl_core_chk.sv
module dma_ctl_core_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] gnt,
  input logic [NCH-1:0] irq,
  input logic           wait_mode,
  input logic           wake,
  input logic           pri,
  input logic           cpu_irq_pend,
  input logic           xfer_step,
  input logic           xfer_last,
  input logic [NCH-1:0] ie,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] armed,
  input logic           wr_stat
);
  assert_gnt_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_wait_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    (wait_mode && !wake) |=> (gnt == '0));

  assert_preempt_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (!pri && cpu_irq_pend && xfer_step && !xfer_last && (gnt != '0)) |=> (gnt == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_irq_needs_ie_R7: assert property (@(posedge clk) disable iff (rst)
      irq[c] |-> $past(ie[c]));
    assert_flag_clear_armed_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(flag[c]) |-> ($past(armed[c]) && $past(wr_stat)));
  end
endmodule

bind dma_ctl_core dma_ctl_core_chk #(.NCH(NCH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .gnt          (gnt),
  .irq          (irq),
  .wait_mode    (wait_mode),
  .wake         (wake_r),
  .pri          (pri_r),
  .cpu_irq_pend (cpu_irq_pend),
  .xfer_step    (xfer_step),
  .xfer_last    (xfer_last),
  .ie           (ie_r),
  .flag         (flag_w),
  .armed        (armed_w),
  .wr_stat      (wr_stat)
);

// File: tb/dma_ctl_core_tb_top.sv
module dma_ctl_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] periph_req = '0;
  logic       cpu_irq_pend = 1'b0, wait_mode = 1'b0;
  logic       xfer_step = 1'b0, xfer_last = 1'b0;
  logic [2:0] gnt, irq, loop_mode;
  logic [1:0] bw;

  always #10 clk = ~clk;

  dma_ctl_core dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .cpu_irq_pend(cpu_irq_pend), .wait_mode(wait_mode), .xfer_step(xfer_step),
    .xfer_last(xfer_last), .gnt(gnt), .bw(bw), .loop_mode(loop_mode), .irq(irq)
  );

  typedef enum int {K_GNT, K_IRQ, K_RD} kind_e;
  typedef struct {
    string      rid;
    kind_e      kind;
    logic [7:0] exp;
    logic [7:0] rd;
  } item_t;

  item_t queue_q[$];
  int    n_vec = 0, n_bad = 0;
  event  sample_ev;

  // monitor: pops expectations and compares with the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (queue_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = queue_q.pop_front();
        case (it.kind)
          K_GNT:   act = {5'b0, gnt};
          K_IRQ:   act = {5'b0, irq};
          default: act = it.rd;
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.rid, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic exp_gnt(string rid, logic [2:0] e);
    item_t it;
    it.rid = rid; it.kind = K_GNT; it.exp = {5'b0, e}; it.rd = '0;
    queue_q.push_back(it);
    -> sample_ev;
  endtask

  task automatic exp_irq(string rid, logic [2:0] e);
    item_t it;
    it.rid = rid; it.kind = K_IRQ; it.exp = {5'b0, e}; it.rd = '0;
    queue_q.push_back(it);
    -> sample_ev;
  endtask

  task automatic exp_rd(string rid, logic [2:0] a, logic [7:0] e);
    item_t it;
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    it.rid = rid; it.kind = K_RD; it.exp = e; it.rd = reg_rdata;
    queue_q.push_back(it);
    -> sample_ev;
  endtask

  task automatic step(logic last);
    xfer_step = 1'b1; xfer_last = last;
    @(negedge clk);
    xfer_step = 1'b0; xfer_last = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    #(20 * 100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    exp_gnt("R1 gnt", 3'b000);
    exp_irq("R1 irq", 3'b000);
    exp_rd("R1 ctrl", 3'd0, 8'h00);
    exp_rd("R1 stat", 3'd1, 8'h00);
    exp_rd("R1 trig", 3'd2, 8'h00);

    // R2 routing: ch0 on source 2
    wr(3'd3, 8'h02);
    wr(3'd0, 8'h03);
    periph_req = 8'h08; idle(3);
    exp_gnt("R2 other source", 3'b000);
    periph_req = 8'h04; idle(2);
    exp_gnt("R2 routed", 3'b001);

    // R5 block end without loop, R7 irq
    step(1'b1); idle(2);
    exp_gnt("R5 released", 3'b000);
    exp_irq("R7 irq0", 3'b001);
    exp_rd("R5 enable cleared", 3'd0, 8'h01);
    // R8 write 0 without read
    wr(3'd1, 8'h00); idle(1);
    exp_rd("R8 unarmed write", 3'd1, 8'h01);
    wr(3'd1, 8'h00); idle(2);
    exp_rd("R8 cleared", 3'd1, 8'h00);
    exp_irq("R8 irq drop", 3'b000);
    periph_req = 8'h00;

    // R3 fixed priority
    wr(3'd3, 8'h04); wr(3'd4, 8'h04);
    wr(3'd0, 8'h0A);
    periph_req = 8'h10; idle(2);
    exp_gnt("R3 ch0 first", 3'b001);
    step(1'b1); idle(2);
    exp_gnt("R3 ch1 next", 3'b010);
    step(1'b1); idle(2);
    exp_gnt("R3 all done", 3'b000);
    exp_irq("R7 no ie", 3'b000);
    exp_rd("R5 flags", 3'd1, 8'h03);
    wr(3'd1, 8'h00);
    periph_req = 8'h00;

    // R4 software trigger
    wr(3'd5, 8'h05);
    wr(3'd0, 8'h20);
    wr(3'd2, 8'h20); idle(1);
    exp_gnt("R4 trig grant", 3'b100);
    exp_rd("R4 trig consumed", 3'd2, 8'h00);
    step(1'b1); idle(2);
    wr(3'd2, 8'h80); idle(2);
    exp_gnt("R4 no taker", 3'b000);
    exp_rd("R4 trig kept", 3'd2, 8'h80);
    wr(3'd2, 8'h00);
    exp_rd("R5 flag2", 3'd1, 8'h04);
    wr(3'd1, 8'h00);

    // R6 loop mode
    wr(3'd1, 8'h10);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h03);
    periph_req = 8'h01; idle(2);
    exp_gnt("R6 grant", 3'b001);
    step(1'b1); idle(3);
    exp_gnt("R6 regrant", 3'b001);
    exp_irq("R6 irq", 3'b001);
    exp_rd("R6 enable kept", 3'd0, 8'h03);
    exp_rd("R6 flag", 3'd1, 8'h11);
    wr(3'd1, 8'h10); idle(2);
    exp_irq("R8 clear loop", 3'b000);

    // R10 priority bit 1
    wr(3'd1, 8'h90);
    cpu_irq_pend = 1'b1;
    step(1'b0); idle(2);
    exp_gnt("R10 held", 3'b001);
    exp_rd("R10 enable", 3'd0, 8'h03);

    // R9 priority bit 0
    wr(3'd1, 8'h10);
    step(1'b0); idle(2);
    exp_gnt("R9 preempted", 3'b000);
    exp_rd("R9 enable cleared", 3'd0, 8'h01);
    exp_rd("R9 no flag", 3'd1, 8'h10);
    cpu_irq_pend = 1'b0;

    // R11 wait mode
    wr(3'd0, 8'h03); idle(2);
    exp_gnt("R11 armed", 3'b001);
    wait_mode = 1'b1; idle(2);
    exp_gnt("R11 suspended", 3'b000);
    wait_mode = 1'b0; idle(2);
    exp_gnt("R11 resumed", 3'b001);
    wr(3'd1, 8'h18);
    wait_mode = 1'b1; idle(2);
    exp_gnt("R11 wake on", 3'b001);
    step(1'b1); idle(3);
    exp_irq("R11 irq in wait", 3'b001);
    wait_mode = 1'b0;

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule